// File: doc/BRIEF.md
# Memory Reference Pipe with Fault Accounting

This block keeps a small register file with one entry for each reference that the memory system accepts. Every accepted reference takes a slot number from a rolling allocator. Its entry records the reference kind, the task that issued it and a subtask field. A fault reported against a slot sets that entry's emulator-fault bit from the report. The allocator skips the two lowest slot numbers. A read that misses on a dirty line takes two slots in a row: the block fetch, then the victim write-back.

Next to the entries sits one fault summary. It keeps a biased three-bit fault count, the slot number of the first fault, and a sticky emulator-fault flag. It also raises a wakeup towards a fault-handler task. The processor reads entries through a read-select register. A read of the summary returns a 16-bit word and restarts the fault count, which also releases the pending wakeup.

Top module: `mref_pipe`

## Requirements
- R1: After reset the allocator holds 2, the fault count is 7, the first-fault slot is 0, the emulator-fault flag, wakeup and read-select are 0, and every entry reads kind 0 (undefined).
- R2: Each single-slot reference takes the current allocator value and advances it by one. The value after 15 is 2, so 0 and 1 are never handed out.
- R3: The entry at the slot taken holds the kind code (0 undefined, 1 storage read, 2 storage write, 3 map or non-storage operation), the task, the subtask and a cleared fault bit. ent_q shows the entry chosen by read-select as {kind[8:7], task[6:3], subtask[2:1], fault[0]}.
- R4: A reference with iss_dirty set takes two consecutive slots, wrapping as in R2. The first slot holds the issued kind and the second holds kind 2. The allocator advances by two.
- R5: The fault count holds the number of faults minus one. A value of 7 means there are no faults, and the first fault of a batch sets the count to 0.
- R6: The first fault of a batch latches its slot number. Later faults leave that field unchanged.
- R7: The count stops at 6 and never wraps back to 7 while faults continue.
- R8: A summary read sets the count to 7 and clears the emulator-fault flag. A fault in the same cycle as the read becomes the first fault of a new batch.
- R9: A fault with wake_dis low sets the wakeup. The wakeup stays set until a summary read. With wake_dis high no new wakeup is raised, but the fault is still counted.
- R10: sum_q is {read-select[15:12], allocator[11:8], count[7:5], first-fault slot[4:1], emulator-fault flag[0]}.
- R11: A fault sets the emulator-fault bit of the faulting entry to flt_emu, and flt_emu also sets the sticky summary flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_v | input | 1 | Reference accepted this cycle |
| iss_kind | input | 2 | Reference kind code |
| iss_dirty | input | 1 | Read missed on a dirty line; takes two slots |
| iss_task | input | 4 | Issuing task number |
| iss_sub | input | 2 | Subtask field |
| flt_v | input | 1 | Fault reported this cycle |
| flt_srn | input | 4 | Slot number of the faulting reference |
| flt_emu | input | 1 | Fault belongs to the emulator |
| sel_wr | input | 1 | Load the read-select register |
| sel_din | input | 4 | New read-select value |
| sum_rd | input | 1 | Read of the fault summary (clears the count) |
| wake_dis | input | 1 | Suppress new fault wakeups |
| ent_q | output | 9 | Entry chosen by read-select |
| sum_q | output | 16 | Fault summary word |
| wake | output | 1 | Pending wakeup to the fault task |

## Verification
All state is updated at the clock edge where an issue, fault, read-select load or summary read is presented. The new allocator, count, first-fault slot, flag and wakeup are therefore due one edge later. ent_q and sum_q are combinational from that state, so they follow in the same cycle. The bench drives each stimulus just after a falling edge and checks at the next falling edge, one rising edge later. The value a summary read returns is sampled before the edge that clears it, and the cleared state is sampled after that edge.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int SRN_W  = 4;
  localparam int TASK_W = 4;
  localparam int SUB_W  = 2;
  localparam int CNT_W  = 3;
  localparam int ENT_W  = 2 + TASK_W + SUB_W + 1;
  localparam int SUM_W  = 3 * SRN_W + CNT_W + 1;

  typedef logic [SRN_W-1:0] srn_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_RD   = 2'd1,
    REF_WR   = 2'd2,
    REF_MAP  = 2'd3
  } ref_kind_e;

  typedef struct packed {
    ref_kind_e           kind;
    logic [TASK_W-1:0]   tsk;
    logic [SUB_W-1:0]    sub;
    logic                efault;
  } pipe_ent_t;

  localparam cnt_t CNT_NONE = '1;
  localparam cnt_t CNT_SAT  = CNT_NONE - cnt_t'(1);

  // Step a slot number by 'step', wrapping past the top back to 'lo'.
  function automatic srn_t srn_advance(srn_t s, int unsigned step, srn_t lo);
    logic [SRN_W:0] t;
    t = {1'b0, s} + (SRN_W+1)'(step);
    if (t > (SRN_W+1)'((1 << SRN_W) - 1))
      t = t - (SRN_W+1)'((1 << SRN_W) - int'(lo));
    return t[SRN_W-1:0];
  endfunction

  // Biased fault count: all-ones = none, stops one below all-ones.
  function automatic cnt_t cnt_bump(cnt_t c);
    if (c == CNT_NONE) return '0;
    if (c == CNT_SAT)  return CNT_SAT;
    return c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/mrp_alloc.sv
module mrp_alloc
  import mrp_pkg::*;
#(
  parameter srn_t FIRST_SRN = srn_t'(2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iss_v,
  input  logic iss_dirty,
  output srn_t slot0,
  output srn_t slot1
);
  srn_t alloc_q;

  assign slot0 = alloc_q;
  assign slot1 = srn_advance(alloc_q, 1, FIRST_SRN);

  always_ff @(posedge clk) begin
    if (!rst_n)
      alloc_q <= FIRST_SRN;
    else if (iss_v)
      alloc_q <= srn_advance(alloc_q, iss_dirty ? 2 : 1, FIRST_SRN);
  end
endmodule

// File: rtl/mrp_entry_file.sv
module mrp_entry_file
  import mrp_pkg::*;
#(
  parameter int SLOTS = 1 << SRN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_v,
  input  srn_t              wr0_idx,
  input  pipe_ent_t         wr0_ent,
  input  logic              wr1_v,
  input  srn_t              wr1_idx,
  input  pipe_ent_t         wr1_ent,
  input  logic              flt_v,
  input  srn_t              flt_idx,
  input  logic              flt_emu,
  input  srn_t              rd_idx,
  output pipe_ent_t         rd_ent
);
  pipe_ent_t ent_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else begin
        if (wr0_v && wr0_idx == srn_t'(i))
          ent_q[i] <= wr0_ent;
        else if (wr1_v && wr1_idx == srn_t'(i))
          ent_q[i] <= wr1_ent;
        if (flt_v && flt_idx == srn_t'(i))
          ent_q[i].efault <= flt_emu;
      end
    end
  end

  assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/mrp_fault_sum.sv
module mrp_fault_sum
  import mrp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flt_v,
  input  srn_t flt_srn,
  input  logic flt_emu,
  input  logic sum_rd,
  input  logic wake_dis,
  output cnt_t cnt_q,
  output srn_t first_q,
  output logic emu_q,
  output logic wake_q
);
  cnt_t base_cnt;
  logic base_emu;

  assign base_cnt = sum_rd ? CNT_NONE : cnt_q;
  assign base_emu = sum_rd ? 1'b0 : emu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= CNT_NONE;
      first_q <= '0;
      emu_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      cnt_q <= flt_v ? cnt_bump(base_cnt) : base_cnt;
      emu_q <= base_emu | (flt_v & flt_emu);
      if (flt_v && base_cnt == CNT_NONE)
        first_q <= flt_srn;
      if (flt_v && !wake_dis)
        wake_q <= 1'b1;
      else if (sum_rd)
        wake_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mref_pipe.sv
module mref_pipe
  import mrp_pkg::*;
#(
  parameter int FIRST_SRN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_v,
  input  logic [1:0]           iss_kind,
  input  logic                 iss_dirty,
  input  logic [TASK_W-1:0]    iss_task,
  input  logic [SUB_W-1:0]     iss_sub,
  input  logic                 flt_v,
  input  logic [SRN_W-1:0]     flt_srn,
  input  logic                 flt_emu,
  input  logic                 sel_wr,
  input  logic [SRN_W-1:0]     sel_din,
  input  logic                 sum_rd,
  input  logic                 wake_dis,
  output logic [ENT_W-1:0]     ent_q,
  output logic [SUM_W-1:0]     sum_q,
  output logic                 wake
);
  localparam int SLOTS = 1 << SRN_W;

  srn_t      slot0, slot1, sel_q, first_q;
  cnt_t      cnt_q;
  logic      emu_q, wake_q;
  logic      two_slot;
  pipe_ent_t ent0, ent1, rd_ent;

  assign two_slot = iss_v & iss_dirty;

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (sel_wr) sel_q <= sel_din;
  end

  mrp_alloc #(.FIRST_SRN(srn_t'(FIRST_SRN))) u_alloc (
    .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_dirty(iss_dirty),
    .slot0(slot0), .slot1(slot1)
  );

  assign ent0 = '{kind: ref_kind_e'(iss_kind), tsk: iss_task, sub: iss_sub, efault: 1'b0};
  assign ent1 = '{kind: REF_WR, tsk: iss_task, sub: iss_sub, efault: 1'b0};

  mrp_entry_file #(.SLOTS(SLOTS)) u_ents (
    .clk(clk), .rst_n(rst_n),
    .wr0_v(iss_v), .wr0_idx(slot0), .wr0_ent(ent0),
    .wr1_v(two_slot), .wr1_idx(slot1), .wr1_ent(ent1),
    .flt_v(flt_v), .flt_idx(flt_srn), .flt_emu(flt_emu),
    .rd_idx(sel_q), .rd_ent(rd_ent)
  );

  mrp_fault_sum u_sum (
    .clk(clk), .rst_n(rst_n), .flt_v(flt_v), .flt_srn(flt_srn),
    .flt_emu(flt_emu), .sum_rd(sum_rd), .wake_dis(wake_dis),
    .cnt_q(cnt_q), .first_q(first_q), .emu_q(emu_q), .wake_q(wake_q)
  );

  assign ent_q = rd_ent;
  assign sum_q = {sel_q, slot0, cnt_q, first_q, emu_q};
  assign wake  = wake_q;
endmodule

// File: rtl/mrp_chk.sv
module mrp_chk
  import mrp_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic flt_v,
  input logic sum_rd,
  input logic wake_dis,
  input srn_t slot0,
  input cnt_t cnt_q,
  input srn_t first_q,
  input logic wake_q
);
  // R2
  alloc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot0 >= srn_t'(2));
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_SAT && flt_v && !sum_rd) |=> cnt_q == CNT_SAT);
  // R6
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_NONE && !sum_rd) |=> $stable(first_q));
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_rd && !flt_v) |=> cnt_q == CNT_NONE);
  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !sum_rd) |=> wake_q);
  // R9
  wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_q && wake_dis) |=> !wake_q);
endmodule

bind mref_pipe mrp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flt_v(flt_v), .sum_rd(sum_rd),
  .wake_dis(wake_dis), .slot0(slot0), .cnt_q(cnt_q),
  .first_q(first_q), .wake_q(wake_q)
);

// File: tb/sim_mref_pipe.sv
`timescale 1ns/1ps
module sim_mref_pipe;
  logic clk = 0, rst_n = 0;
  logic iss_v = 0, iss_dirty = 0, flt_v = 0, flt_emu = 0;
  logic sel_wr = 0, sum_rd = 0, wake_dis = 0;
  logic [1:0] iss_kind = 0, iss_sub = 2'b10;
  logic [3:0] iss_task = 0, flt_srn = 0, sel_din = 0;
  logic [8:0] ent_q;
  logic [15:0] sum_q;
  logic wake;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mref_pipe u0 (.*);

  typedef struct packed {
    logic iv; logic [1:0] k; logic dm; logic [3:0] tk;
    logic fv; logic [3:0] fs; logic rd;
    logic [3:0] ea; logic [2:0] ec; logic [3:0] ef; logic ew;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b1, 2'd1, 1'b0, 4'd3, 1'b0, 4'd0, 1'b0, 4'd3, 3'd7, 4'd0, 1'b0},
    '{1'b1, 2'd1, 1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 4'd5, 3'd7, 4'd0, 1'b0},
    '{1'b1, 2'd3, 1'b0, 4'd7, 1'b0, 4'd0, 1'b0, 4'd6, 3'd7, 4'd0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 4'd4, 1'b0, 4'd6, 3'd0, 4'd4, 1'b1},
    '{1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 4'd6, 3'd1, 4'd4, 1'b1},
    '{1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd6, 3'd7, 4'd4, 1'b0},
    '{1'b1, 2'd2, 1'b0, 4'd1, 1'b1, 4'd6, 1'b0, 4'd7, 3'd0, 4'd6, 1'b1},
    '{1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 4'd2, 1'b1, 4'd7, 3'd0, 4'd2, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_v = 0; iss_dirty = 0; flt_v = 0; flt_emu = 0; sel_wr = 0; sum_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic look(input int s);
    sel_wr = 1; sel_din = 4'(s);
    step();
  endtask

  task automatic fault(input int s, input bit e);
    flt_v = 1; flt_srn = 4'(s); flt_emu = e;
    step();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R10 reset state
    chk(sum_q == 16'h0_2_E0 >> 0 || sum_q == {4'd0, 4'd2, 3'd7, 4'd0, 1'b0}, "R1", sum_q,
        {4'd0, 4'd2, 3'd7, 4'd0, 1'b0});
    chk(wake == 0, "R1", wake, 0);
    chk(ent_q[8:7] == 2'd0, "R1", ent_q[8:7], 0);

    for (int i = 0; i < 8; i++) begin
      iss_v = VT[i].iv; iss_kind = VT[i].k; iss_dirty = VT[i].dm; iss_task = VT[i].tk;
      flt_v = VT[i].fv; flt_srn = VT[i].fs; flt_emu = 0; sum_rd = VT[i].rd;
      step();
      // R2 R4 R5 R6 R8 R9 table
      chk(sum_q[11:8] == VT[i].ea, "R2/R4 alloc", sum_q[11:8], VT[i].ea);
      chk(sum_q[7:5] == VT[i].ec, "R5/R8 count", sum_q[7:5], VT[i].ec);
      if (VT[i].ec != 3'd7)
        chk(sum_q[4:1] == VT[i].ef, "R6 first", sum_q[4:1], VT[i].ef);
      chk(wake == VT[i].ew, "R9 wake", wake, VT[i].ew);
    end

    // R3 R4 entry contents
    look(2); chk(ent_q == {2'd1, 4'd3, 2'b10, 1'b0}, "R3 slot2", ent_q, {2'd1, 4'd3, 2'b10, 1'b0});
    look(3); chk(ent_q == {2'd1, 4'd5, 2'b10, 1'b0}, "R4 slot3", ent_q, {2'd1, 4'd5, 2'b10, 1'b0});
    look(4); chk(ent_q[8:7] == 2'd2 && ent_q[6:3] == 4'd5, "R4 slot4", ent_q, {2'd2, 4'd5, 2'b10, 1'b0});
    look(5); chk(ent_q[8:7] == 2'd3, "R3 slot5", ent_q[8:7], 3);
    chk(sum_q[15:12] == 4'd5, "R10 select", sum_q[15:12], 5);

    // R2 R4 wrap: 8 singles from 7 reach 15, then a two-slot miss uses 15 and 2
    for (int i = 0; i < 8; i++) begin
      iss_v = 1; iss_kind = 2'd1; iss_task = 4'd9;
      step();
    end
    chk(sum_q[11:8] == 4'd15, "R2 top", sum_q[11:8], 15);
    iss_v = 1; iss_kind = 2'd1; iss_dirty = 1; iss_task = 4'd12;
    step();
    chk(sum_q[11:8] == 4'd3, "R2/R4 wrap", sum_q[11:8], 3);
    look(15); chk(ent_q[8:7] == 2'd1 && ent_q[6:3] == 4'd12, "R4 slot15", ent_q, {2'd1, 4'd12, 2'b10, 1'b0});
    look(2);  chk(ent_q[8:7] == 2'd2 && ent_q[6:3] == 4'd12, "R4 slot2", ent_q, {2'd2, 4'd12, 2'b10, 1'b0});

    // R7 saturation after nine faults
    sum_rd = 1; step();
    chk(sum_q[7:5] == 3'd7 && wake == 0, "R8 clear", sum_q[7:5], 7);
    for (int i = 0; i < 9; i++) fault(5, 0);
    chk(sum_q[7:5] == 3'd6, "R7 sat", sum_q[7:5], 6);
    chk(sum_q[4:1] == 4'd5, "R6 first", sum_q[4:1], 5);
    sum_rd = 1;
    #1 chk(sum_q[7:5] == 3'd6, "R8 read value", sum_q[7:5], 6);
    step();
    chk(sum_q[7:5] == 3'd7, "R8 after read", sum_q[7:5], 7);

    // R9 R11 masked wakeup, emulator fault
    wake_dis = 1;
    fault(3, 1);
    chk(sum_q[7:5] == 3'd0, "R9 counted", sum_q[7:5], 0);
    chk(wake == 0, "R9 masked", wake, 0);
    chk(sum_q[0] == 1, "R11 flag", sum_q[0], 1);
    wake_dis = 0;
    look(3);
    chk(ent_q[0] == 1, "R11 entry", ent_q[0], 1);
    chk(wake == 0, "R9 still quiet", wake, 0);
    sum_rd = 1; step();
    chk(sum_q[0] == 0, "R8/R11 flag clear", sum_q[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule